// File: doc/BRIEF.md
# Multi-Source System Reset Sequencer

This block merges three reasons for holding a digital core in reset and produces one registered, active-high system reset. The first reason is loss of supply, reported by a power-good input from an analog monitor. The second is a watchdog that software must refresh with a kick pulse. The third is an active-low reset pin from the board. The pin is noisy, so it is first brought into the clock domain by a flop chain. It then has to stay low for a minimum number of consecutive samples before it counts as a request.

After every request has gone away, the reset is held for a further fixed number of cycles before the core is released. When the core is released it starts from address zero, which the block presents on a restart-address output. The oscillator-enable output stays high through pin and watchdog resets. It drops only while power is bad.

A sticky cause register shows which sources have asserted since it was last cleared. Software clears it by writing ones to the cause-clear strobe.

The sequencer is a three-state machine:
- HOLD: at least one source is active.
- STRETCH: the release counter is running.
- RUN: the core is released.

Its transitions are:
- HOLD to STRETCH: every source has gone quiet.
- STRETCH to HOLD: a source returns before the count ends.
- STRETCH to RUN: the counter reaches its end.
- RUN to HOLD: any source asserts.

Power loss is an asynchronous reset of the whole block. Its release is synchronized, and the machine restarts in HOLD.

Top module: `sysrst_hub`

## Requirements
- R1: While `pwr_ok` is low, `sys_rst` is 1 and `osc_keep` is 0, and `cause` reads 3'b001 (bit 0 = power), all without waiting for a clock edge.
- R2: After `pwr_ok` rises, `sys_rst` falls between STRETCH and STRETCH+8 cycles later (STRETCH defaults to 4096).
- R3: A low pulse on `ext_rst_n` that lasts fewer than PIN_MIN clock cycles (default 32) leaves `sys_rst` at 0 and `cause` bit 2 at 0.
- R4: A low level on `ext_rst_n` that lasts PIN_MIN cycles or more raises `sys_rst` between PIN_MIN and PIN_MIN+6 cycles after the pin falls.
- R5: `sys_rst` stays 1 for as long as the pin is held low. It falls between STRETCH and STRETCH+8 cycles after the pin returns high.
- R6: If `wdt_kick` is absent for WDT_LIMIT cycles of run time, `sys_rst` rises and `cause` bit 1 sets.
- R7: Kicks spaced closer than WDT_LIMIT cycles keep `sys_rst` at 0 indefinitely.
- R8: The cause bits are: bit 0 = power, bit 1 = watchdog, bit 2 = pin. Each bit is sticky. A 1 on the matching `cause_clr` bit clears it. A source that is active in the same cycle as the clear keeps its bit at 1.
- R9: `osc_keep` stays 1 during pin and watchdog resets.
- R10: `restart_addr` is all zeros.
- R11: The watchdog count is held at zero while `sys_rst` is 1. The first timeout after a release therefore comes a full WDT_LIMIT cycles after that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| pwr_ok | input | 1 | Supply good from the analog monitor; low resets everything asynchronously |
| ext_rst_n | input | 1 | Asynchronous active-low board reset pin |
| wdt_kick | input | 1 | Single-cycle software refresh of the watchdog |
| cause_clr | input | 3 | Write-one-to-clear mask for the cause bits |
| sys_rst | output | 1 | Registered active-high reset to the digital core |
| osc_keep | output | 1 | Keeps clock management and oscillators enabled |
| restart_addr | output | ADDR_W | Fetch address after release, always zero |
| cause | output | 3 | Sticky reset causes: bit 0 power, bit 1 watchdog, bit 2 pin |

## Verification
A clear strobe on the cause register can land in the same cycle as an active source trying to set that bit. The bench provokes this by holding the pin low well past the filter time, so the pin bit is set again on every cycle. During that hold it pulses a clear that targets both the pin bit and the stale watchdog bit. The expected outcome is that the watchdog bit drops while the pin bit stays at 1, because setting takes priority over clearing.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } seq_state_e;

    localparam int CAUSE_W   = 3;
    localparam int CAUSE_PWR = 0;
    localparam int CAUSE_WDT = 1;
    localparam int CAUSE_PIN = 2;

endpackage

// File: rtl/sysrst_pin_filter.sv
module sysrst_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_req
);
    localparam int CW = (MIN_LOW > 1) ? $clog2(MIN_LOW) : 1;
    localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt;
    logic                   pin_hi;
    logic                   req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    assign pin_hi = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            req_q   <= 1'b0;
        end else if (pin_hi) begin
            low_cnt <= '0;
            req_q   <= 1'b0;
        end else begin
            if (low_cnt != LAST) low_cnt <= low_cnt + 1'b1;
            req_q <= req_q || (low_cnt == LAST);
        end
    end

    assign pin_req = req_q;

    assert_high_drops_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_hi |=> !pin_req);
    assert_req_needs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_req) |-> $past(!pin_hi));

endmodule

// File: rtl/sysrst_wdog.sv
module sysrst_wdog #(
    parameter int LIMIT = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic kick,
    output logic bite
);
    localparam int WW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [WW-1:0] TOP = WW'(LIMIT - 1);

    logic [WW-1:0] cnt_q;
    logic          bite_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bite_q <= 1'b0;
        end else if (hold || kick) begin
            cnt_q  <= '0;
            bite_q <= 1'b0;
        end else if (cnt_q == TOP) begin
            cnt_q  <= '0;
            bite_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            bite_q <= 1'b0;
        end
    end

    assign bite = bite_q;

    assert_hold_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt_q == '0) && !bite);
    assert_bite_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bite |=> !bite);

endmodule

// File: rtl/sysrst_cause.sv
module sysrst_cause
    import sysrst_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set,
    input  logic [CAUSE_W-1:0] clr,
    output logic [CAUSE_W-1:0] q
);
    localparam logic [CAUSE_W-1:0] AFTER_POWER = CAUSE_W'(1) << CAUSE_PWR;

    logic [CAUSE_W-1:0] q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= AFTER_POWER;
        else        q_r <= (q_r & ~clr) | set;
    end

    assign q = q_r;

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((q & $past(set)) == $past(set)));
    assert_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((set == '0) && (clr != '0)) |=> ((q & $past(clr)) == '0));

endmodule

// File: rtl/sysrst_hub.sv
module sysrst_hub
    import sysrst_pkg::*;
#(
    parameter int STRETCH     = 4096,
    parameter int PIN_MIN     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int WDT_LIMIT   = 16384,
    parameter int ADDR_W      = 16
) (
    input  logic               clk,
    input  logic               pwr_ok,
    input  logic               ext_rst_n,
    input  logic               wdt_kick,
    input  logic [CAUSE_W-1:0] cause_clr,
    output logic               sys_rst,
    output logic               osc_keep,
    output logic [ADDR_W-1:0]  restart_addr,
    output logic [CAUSE_W-1:0] cause
);
    localparam int SW = (STRETCH > 1) ? $clog2(STRETCH) : 1;
    localparam logic [SW-1:0] STRETCH_END = SW'(STRETCH - 1);

    logic [1:0]         por_q;
    logic               rst_n;
    logic               osc_q;
    logic               sys_rst_q;
    logic               pin_req;
    logic               wdt_bite;
    logic               src_any;
    logic [SW-1:0]      hold_cnt;
    logic [CAUSE_W-1:0] cause_set;
    seq_state_e         state_q, state_d;

    // power-good release is brought into the clock domain
    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) por_q <= 2'b00;
        else         por_q <= {por_q[0], 1'b1};
    end
    assign rst_n = por_q[1];

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) osc_q <= 1'b0;
        else         osc_q <= 1'b1;
    end

    sysrst_pin_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_LOW     (PIN_MIN)
    ) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (ext_rst_n),
        .pin_req (pin_req)
    );

    sysrst_wdog #(
        .LIMIT (WDT_LIMIT)
    ) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (sys_rst_q),
        .kick  (wdt_kick),
        .bite  (wdt_bite)
    );

    assign src_any = pin_req | wdt_bite;

    always_comb begin
        cause_set            = '0;
        cause_set[CAUSE_WDT] = wdt_bite;
        cause_set[CAUSE_PIN] = pin_req;
    end

    sysrst_cause u_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (cause_set),
        .clr   (cause_clr),
        .q     (cause)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    state_d = src_any ? ST_HOLD : ST_STRETCH;
            ST_STRETCH: begin
                if (src_any)                     state_d = ST_HOLD;
                else if (hold_cnt == STRETCH_END) state_d = ST_RUN;
            end
            ST_RUN:     state_d = src_any ? ST_HOLD : ST_RUN;
            default:    state_d = ST_HOLD;
        endcase
    end

    // state register with its release counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_HOLD;
            hold_cnt <= '0;
        end else begin
            state_q  <= state_d;
            if (state_q == ST_STRETCH && state_d == ST_STRETCH) hold_cnt <= hold_cnt + 1'b1;
            else                                                 hold_cnt <= '0;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sys_rst_q <= 1'b1;
        else        sys_rst_q <= (state_d != ST_RUN);
    end

    assign sys_rst      = sys_rst_q;
    assign osc_keep     = osc_q;
    assign restart_addr = '0;

    assert_source_resets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        src_any |=> sys_rst);
    assert_run_is_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> !sys_rst);
    assert_stretch_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRETCH) |-> sys_rst);
    assert_osc_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> osc_keep);

endmodule

// File: tb/test_sysrst_hub.sv
module test_sysrst_hub;
    localparam int CLK_PERIOD = 10;
    localparam int STRETCH    = 4096;
    localparam int PIN_MIN    = 32;
    localparam int WDT_LIMIT  = 16384;
    localparam int ADDR_W     = 16;

    logic              clk = 1'b0;
    logic              pwr_ok = 1'b0;
    logic              ext_rst_n = 1'b1;
    logic              wdt_kick = 1'b0;
    logic [2:0]        cause_clr = 3'b000;
    logic              sys_rst;
    logic              osc_keep;
    logic [ADDR_W-1:0] restart_addr;
    logic [2:0]        cause;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        string req;
        int    got;
        int    exp;
    } item_t;
    item_t sb[$];

    sysrst_hub #(
        .STRETCH (STRETCH), .PIN_MIN (PIN_MIN), .SYNC_STAGES (2),
        .WDT_LIMIT (WDT_LIMIT), .ADDR_W (ADDR_W)
    ) i_sysrst_hub (
        .clk (clk), .pwr_ok (pwr_ok), .ext_rst_n (ext_rst_n), .wdt_kick (wdt_kick),
        .cause_clr (cause_clr), .sys_rst (sys_rst), .osc_keep (osc_keep),
        .restart_addr (restart_addr), .cause (cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // driver side: snapshot observation plus expectation
    task automatic expect_val(input string req, input int got, input int exp);
        item_t it;
        it.req = req; it.got = got; it.exp = exp;
        sb.push_back(it);
    endtask

    // monitor side: pops and judges
    task automatic drain();
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (it.got != it.exp) begin
                bad++;
                $display("FAIL %s: got=%0d exp=%0d", it.req, it.got, it.exp);
            end
        end
    endtask

    always @(negedge clk) drain();

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kick();
        @(negedge clk); wdt_kick = 1'b1;
        @(negedge clk); wdt_kick = 1'b0;
    endtask

    task automatic clear(input logic [2:0] m);
        @(negedge clk); cause_clr = m;
        @(negedge clk); cause_clr = 3'b000;
        #1;
    endtask

    task automatic wait_rst(input logic val, input int limit, output int n);
        n = 0;
        while (sys_rst !== val && n < limit) begin
            @(negedge clk); n++;
        end
        #1;
    endtask

    function automatic int in_win(input int v, input int lo, input int hi);
        return (v >= lo && v <= hi) ? 1 : 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int t_fall;
        bit seen;

        // R1 reset state while supply is bad
        step(5); #1;
        expect_val("R1 sys_rst in power loss", sys_rst, 1);
        expect_val("R1 osc_keep in power loss", osc_keep, 0);
        expect_val("R1 cause after power loss", cause, 3'b001);

        // R2 release after power good
        @(negedge clk); pwr_ok = 1'b1;
        wait_rst(1'b0, STRETCH + 100, n);
        expect_val($sformatf("R2 power release delay %0d in window", n),
                   in_win(n, STRETCH, STRETCH + 8), 1);
        expect_val("R10 restart address zero", restart_addr, 0);
        expect_val("R9 osc_keep after release", osc_keep, 1);
        expect_val("R8 cause keeps power bit", cause, 3'b001);
        clear(3'b001);
        expect_val("R8 power bit cleared", cause, 3'b000);

        // R7 regular kicks
        seen = 0;
        for (int k = 0; k < 5; k++) begin
            kick();
            for (int c = 0; c < 8000; c++) begin
                @(negedge clk);
                if (sys_rst) seen = 1;
            end
        end
        expect_val("R7 kicked watchdog never fires", seen, 0);

        // R3 short pin pulse ignored
        kick();
        @(negedge clk); ext_rst_n = 1'b0;
        step(PIN_MIN - 1);
        ext_rst_n = 1'b1;
        seen = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (sys_rst) seen = 1;
        end
        #1;
        expect_val("R3 short pulse gives no reset", seen, 0);
        expect_val("R3 short pulse leaves pin cause", cause[2], 0);

        // R4 long pin pulse
        kick();
        @(negedge clk); ext_rst_n = 1'b0;
        wait_rst(1'b1, 200, n);
        expect_val($sformatf("R4 pin reset delay %0d in window", n),
                   in_win(n, PIN_MIN, PIN_MIN + 6), 1);
        step(100); #1;
        expect_val("R5 reset held while pin low", sys_rst, 1);
        expect_val("R9 osc_keep during pin reset", osc_keep, 1);
        @(negedge clk); ext_rst_n = 1'b1;
        wait_rst(1'b0, STRETCH + 100, n);
        t_fall = cyc;
        expect_val($sformatf("R5 pin release delay %0d in window", n),
                   in_win(n, STRETCH, STRETCH + 8), 1);
        expect_val("R8 pin cause recorded", cause, 3'b100);
        clear(3'b100);

        // R6 / R11 watchdog timeout measured from release
        wait_rst(1'b1, WDT_LIMIT + 100, n);
        n = cyc - t_fall;
        expect_val($sformatf("R11 timeout after release %0d in window", n),
                   in_win(n, WDT_LIMIT, WDT_LIMIT + 4), 1);
        expect_val("R6 watchdog cause recorded", cause, 3'b010);
        expect_val("R9 osc_keep during watchdog reset", osc_keep, 1);
        wait_rst(1'b0, STRETCH + 100, n);
        expect_val("R6 watchdog reset releases", sys_rst, 0);

        // R8 clear colliding with an active pin source
        kick();
        @(negedge clk); ext_rst_n = 1'b0;
        wait_rst(1'b1, 200, n);
        step(5);
        clear(3'b110);
        expect_val("R8 set wins over clear, other bit cleared", cause, 3'b100);
        @(negedge clk); ext_rst_n = 1'b1;
        wait_rst(1'b0, STRETCH + 100, n);
        clear(3'b111);
        expect_val("R8 full clear", cause, 3'b000);

        // R1 power loss in the middle of run
        @(negedge clk); pwr_ok = 1'b0;
        #1;
        expect_val("R1 immediate reset on power loss", sys_rst, 1);
        expect_val("R1 osc_keep dropped on power loss", osc_keep, 0);
        expect_val("R1 power cause after loss", cause, 3'b001);

        step(2);
        drain();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule